// File: doc/BRIEF.md
# Dynamic Predication Fetch Controller

This block steers instruction fetch while a hard-to-predict conditional branch is being executed down both of its sides. When the front end fetches a branch that the compiler has tagged as a candidate and the confidence estimator rates as low, the controller latches the branch's merge addresses and the opposite-direction target, and it asks for an enter-predicted-path marker micro-op. Fetch then follows the branch predictor until the next predicted fetch address hits one of the merge addresses. At that point the controller redirects fetch to the other side of the branch and asks for an enter-alternate-path marker. When the alternate side reaches the same merge address, the controller requests an exit marker and returns to normal mode.

The block also handles the ways an episode ends early. The alternate side may run longer than a per-branch instruction budget. The tagged branch may resolve before the exit, with either outcome, on either side. A new candidate branch may appear on the predicted side. A flush caused by some other branch may require the whole mode context to be restored from a checkpoint. Each cycle produces at most one event, with a redirect or flush where that event needs one. All outputs are registered, so an event appears one clock after the inputs that caused it. The branch predictor, rename checkpoints and pipeline sit outside the block.

States: NORMAL (mode 0), PRED_PATH (mode 1) and ALT_PATH (mode 2). Transitions: NORMAL to PRED_PATH on a qualifying branch (enter). PRED_PATH to PRED_PATH on a new qualifying branch (re-enter). PRED_PATH to ALT_PATH on a merge hit (switch). ALT_PATH to NORMAL on a merge hit (exit), on an exhausted budget (early exit) or on resolution. PRED_PATH to NORMAL on resolution. Any state to the checkpointed state on restore.

Top module: `dpf_fetch_ctrl`

## Requirements
- R1: A branch is qualifying when br_valid, br_marked and br_lowconf are all 1. In NORMAL, a qualifying branch produces evt=1 (ENTER_PRED) and mode=1 one cycle later. The controller latches the merge table, the valid mask, the budget, and the alternate target, which is br_nt_tgt when br_pred_taken=1 and br_taken_tgt otherwise. A branch missing either flag has no effect: evt stays 0 and mode stays 0.
- R2: In PRED_PATH, when next_fetch_addr equals any valid latched merge entry, the next cycle shows evt=2 (ENTER_ALT), redir_valid=1 with redir_addr set to the latched alternate target, and mode=2.
- R3: Entries whose valid bit is 0 never match. When several entries match at once, the lowest index is taken. In ALT_PATH only that locked entry can end the path; the other entries are ignored.
- R4: In ALT_PATH, a match on the locked entry produces evt=3 (EXIT), redir_valid=0 and mode=0.
- R5: In ALT_PATH, each cycle with fetch_valid=1 advances a saturating 8-bit count that starts at 0 on the switch. When the advanced count is at least the latched budget, the next cycle shows evt=4 (EARLY_EXIT), a redirect to the locked merge address, and mode=0. A locked-entry match in the same cycle wins, giving EXIT.
- R6: In PRED_PATH, a new qualifying branch restarts the episode with evt=1. The new branch's merge table, targets and budget replace the old ones.
- R7: In ALT_PATH, qualifying branches are ignored: no event is raised and the latched context is kept.
- R8: A resolution (res_valid=1) in ALT_PATH ends the episode with mode=0. A correct prediction (res_mispred=0) gives evt=5 (RES_REDIRECT) with a redirect to the locked merge address. A misprediction gives evt=6 (RES_RELEASE) with no redirect.
- R9: A resolution in PRED_PATH ends the episode with mode=0. A correct prediction gives evt=6. A misprediction gives evt=7 (RES_FLUSH) with flush_req=1.
- R10: A resolution outranks a merge hit, a budget exit and a qualifying branch in the same cycle. A resolution in NORMAL has no effect.
- R11: ckpt_save copies the whole mode context. ckpt_restore reinstates that copy, with evt=0 on the next cycle, and outranks every other input.
- R12: During and right after reset, mode=0, evt=0, redir_valid=0, redir_addr=0 and flush_req=0.
- R13: Each cycle carries at most one event. redir_valid is 1 only with evt 2, 4 or 5, and flush_req is 1 only with evt 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | A branch descriptor is present this cycle |
| br_marked | input | 1 | The branch is a compiler-tagged candidate |
| br_lowconf | input | 1 | The confidence estimator rates the branch as low |
| br_pred_taken | input | 1 | Predicted direction of the branch |
| br_taken_tgt | input | ADDR_W | Taken target |
| br_nt_tgt | input | ADDR_W | Not-taken (fall-through) target |
| br_merge_addr | input | MERGE_N*ADDR_W | Merge addresses; entry i at bits [i*ADDR_W +: ADDR_W] |
| br_merge_vld | input | MERGE_N | Valid bit per merge entry |
| br_alt_limit | input | CNT_W | Alternate-path instruction budget |
| next_fetch_addr | input | ADDR_W | Next predicted fetch address |
| fetch_valid | input | 1 | An instruction was fetched this cycle |
| res_valid | input | 1 | The tagged branch resolved this cycle |
| res_mispred | input | 1 | The resolved branch was mispredicted |
| ckpt_save | input | 1 | Save the mode context |
| ckpt_restore | input | 1 | Restore the saved mode context |
| mode | output | 2 | 0 NORMAL, 1 PRED_PATH, 2 ALT_PATH |
| evt | output | 3 | Marker/event code (0 none ... 7 flush) |
| redir_valid | output | 1 | Fetch redirect request |
| redir_addr | output | ADDR_W | Redirect target (0 when no redirect) |
| flush_req | output | 1 | Pipeline flush request |

## Verification
The main function is driven with both predicted directions, so the redirect target shows whether the opposite side was chosen. The merge tables mix invalid entries, duplicate addresses and distinct addresses, which separates any-entry matching on the predicted side from locked-entry matching on the alternate side. Alternate paths end in three ways: a locked match, an exhausted budget, and both in the same cycle. Resolutions are applied on each side with both outcomes, which tells the four resolution events apart, and they are also applied together with competing hits and restores to check priority.

// File: rtl/dpf_pkg.sv
package dpf_pkg;
    typedef enum logic [1:0] {
        M_NORMAL = 2'd0,
        M_PRED   = 2'd1,
        M_ALT    = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        EV_NONE        = 3'd0,
        EV_ENTER_PRED  = 3'd1,
        EV_ENTER_ALT   = 3'd2,
        EV_EXIT        = 3'd3,
        EV_EARLY_EXIT  = 3'd4,
        EV_RES_REDIR   = 3'd5,
        EV_RES_RELEASE = 3'd6,
        EV_RES_FLUSH   = 3'd7
    } evt_e;
endpackage

// File: rtl/dpf_merge_match.sv
// Associative merge-address compare; lowest matching index wins.
module dpf_merge_match #(
    parameter int ADDR_W  = 32,
    parameter int MERGE_N = 4,
    parameter int IDX_W   = 2
) (
    input  logic [MERGE_N*ADDR_W-1:0] tab,
    input  logic [MERGE_N-1:0]        vld,
    input  logic                      lock_en,
    input  logic [IDX_W-1:0]          lock_idx,
    input  logic [ADDR_W-1:0]         probe,
    output logic                      hit,
    output logic [IDX_W-1:0]          hit_idx
);
    logic [MERGE_N-1:0] eq;

    for (genvar g = 0; g < MERGE_N; g++) begin : g_ent
        assign eq[g] = vld[g] && (tab[g*ADDR_W +: ADDR_W] == probe)
                       && (!lock_en || (lock_idx == IDX_W'(g)));
    end

    always_comb begin
        hit     = |eq;
        hit_idx = '0;
        for (int i = MERGE_N - 1; i >= 0; i--) begin
            if (eq[i]) hit_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/dpf_sat_inc.sv
// Saturating increment for the alternate-path budget count.
module dpf_sat_inc #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] a,
    output logic [CNT_W-1:0] y
);
    assign y = (a == {CNT_W{1'b1}}) ? a : a + CNT_W'(1);
endmodule

// File: rtl/dpf_fetch_ctrl.sv
module dpf_fetch_ctrl
    import dpf_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int MERGE_N = 4,
    parameter int CNT_W   = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      br_valid,
    input  logic                      br_marked,
    input  logic                      br_lowconf,
    input  logic                      br_pred_taken,
    input  logic [ADDR_W-1:0]         br_taken_tgt,
    input  logic [ADDR_W-1:0]         br_nt_tgt,
    input  logic [MERGE_N*ADDR_W-1:0] br_merge_addr,
    input  logic [MERGE_N-1:0]        br_merge_vld,
    input  logic [CNT_W-1:0]          br_alt_limit,
    input  logic [ADDR_W-1:0]         next_fetch_addr,
    input  logic                      fetch_valid,
    input  logic                      res_valid,
    input  logic                      res_mispred,
    input  logic                      ckpt_save,
    input  logic                      ckpt_restore,
    output logic [1:0]                mode,
    output logic [2:0]                evt,
    output logic                      redir_valid,
    output logic [ADDR_W-1:0]         redir_addr,
    output logic                      flush_req
);
    localparam int IDX_W = (MERGE_N > 1) ? $clog2(MERGE_N) : 1;

    typedef struct packed {
        mode_e                     st;
        logic [MERGE_N*ADDR_W-1:0] tab;
        logic [MERGE_N-1:0]        vld;
        logic [IDX_W-1:0]          sel;
        logic [ADDR_W-1:0]         alt_tgt;
        logic [CNT_W-1:0]          cnt;
        logic [CNT_W-1:0]          lim;
    } ctx_t;

    ctx_t              ctx_q, ctx_d, shadow_q;
    evt_e              ev_d;
    logic              qualify;
    logic              hit;
    logic [IDX_W-1:0]  hit_idx;
    logic [CNT_W-1:0]  cnt_inc;
    logic [ADDR_W-1:0] lock_addr;
    logic              rv_d;
    logic [ADDR_W-1:0] ra_d;

    assign qualify   = br_valid && br_marked && br_lowconf;
    assign lock_addr = ctx_q.tab[ctx_q.sel*ADDR_W +: ADDR_W];

    dpf_merge_match #(.ADDR_W(ADDR_W), .MERGE_N(MERGE_N), .IDX_W(IDX_W)) u_match (
        .tab     (ctx_q.tab),
        .vld     (ctx_q.vld),
        .lock_en (ctx_q.st == M_ALT),
        .lock_idx(ctx_q.sel),
        .probe   (next_fetch_addr),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    dpf_sat_inc #(.CNT_W(CNT_W)) u_inc (
        .a(ctx_q.cnt),
        .y(cnt_inc)
    );

    // Event decision: restore > resolution > re-entry > merge hit > budget.
    always_comb begin
        ev_d = EV_NONE;
        if (!ckpt_restore) begin
            unique case (ctx_q.st)
                M_NORMAL: begin
                    if (qualify) ev_d = EV_ENTER_PRED;
                end
                M_PRED: begin
                    if (res_valid)    ev_d = res_mispred ? EV_RES_FLUSH : EV_RES_RELEASE;
                    else if (qualify) ev_d = EV_ENTER_PRED;
                    else if (hit)     ev_d = EV_ENTER_ALT;
                end
                M_ALT: begin
                    if (res_valid) ev_d = res_mispred ? EV_RES_RELEASE : EV_RES_REDIR;
                    else if (hit)  ev_d = EV_EXIT;
                    else if (fetch_valid && (cnt_inc >= ctx_q.lim)) ev_d = EV_EARLY_EXIT;
                end
                default: ev_d = EV_NONE;
            endcase
        end
    end

    // Next mode context.
    always_comb begin
        ctx_d = ctx_q;
        if (ckpt_restore) begin
            ctx_d = shadow_q;
        end else begin
            unique case (ev_d)
                EV_ENTER_PRED: begin
                    ctx_d.st      = M_PRED;
                    ctx_d.tab     = br_merge_addr;
                    ctx_d.vld     = br_merge_vld;
                    ctx_d.lim     = br_alt_limit;
                    ctx_d.alt_tgt = br_pred_taken ? br_nt_tgt : br_taken_tgt;
                    ctx_d.sel     = '0;
                    ctx_d.cnt     = '0;
                end
                EV_ENTER_ALT: begin
                    ctx_d.st  = M_ALT;
                    ctx_d.sel = hit_idx;
                    ctx_d.cnt = '0;
                end
                EV_EXIT, EV_EARLY_EXIT, EV_RES_REDIR,
                EV_RES_RELEASE, EV_RES_FLUSH: begin
                    ctx_d.st = M_NORMAL;
                end
                default: begin
                    if (ctx_q.st == M_ALT && fetch_valid) ctx_d.cnt = cnt_inc;
                end
            endcase
        end
    end

    // Redirect target for the chosen event.
    always_comb begin
        rv_d = 1'b0;
        ra_d = '0;
        unique case (ev_d)
            EV_ENTER_ALT: begin
                rv_d = 1'b1;
                ra_d = ctx_q.alt_tgt;
            end
            EV_EARLY_EXIT, EV_RES_REDIR: begin
                rv_d = 1'b1;
                ra_d = lock_addr;
            end
            default: begin
                rv_d = 1'b0;
                ra_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q       <= '0;
            shadow_q    <= '0;
            evt         <= '0;
            redir_valid <= 1'b0;
            redir_addr  <= '0;
            flush_req   <= 1'b0;
        end else begin
            ctx_q       <= ctx_d;
            if (ckpt_save) shadow_q <= ctx_q;
            evt         <= ev_d;
            redir_valid <= rv_d;
            redir_addr  <= ra_d;
            flush_req   <= (ev_d == EV_RES_FLUSH);
        end
    end

    assign mode = ctx_q.st;
endmodule

// File: rtl/dpf_fetch_ctrl_chk.sv
module dpf_fetch_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       br_valid,
    input logic       br_marked,
    input logic       br_lowconf,
    input logic       res_valid,
    input logic       ckpt_restore,
    input logic [1:0] mode,
    input logic [2:0] evt,
    input logic       redir_valid,
    input logic       flush_req
);
    logic qual;
    assign qual = br_valid && br_marked && br_lowconf;

    a_r1_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && qual && !ckpt_restore) |=> (evt == 3'd1 && mode == 2'd1));

    a_r7_alt_ignores_branch: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && qual && !res_valid && !ckpt_restore) |=> (evt != 3'd1));

    a_r2_switch_lands_alt: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == 3'd2) |-> (mode == 2'd2 && redir_valid));

    a_r9_flush_from_pred: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> (evt == 3'd7 && mode == 2'd0 && $past(mode) == 2'd1));

    a_r10_idle_resolution: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && res_valid && !qual) |=> (evt == 3'd0));

    a_r11_restore_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_restore |=> (evt == 3'd0 && !redir_valid && !flush_req));

    a_r13_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'd3);

    a_r13_redirect_events: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> (evt == 3'd2 || evt == 3'd4 || evt == 3'd5));
endmodule

bind dpf_fetch_ctrl dpf_fetch_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .br_valid    (br_valid),
    .br_marked   (br_marked),
    .br_lowconf  (br_lowconf),
    .res_valid   (res_valid),
    .ckpt_restore(ckpt_restore),
    .mode        (mode),
    .evt         (evt),
    .redir_valid (redir_valid),
    .flush_req   (flush_req)
);

// File: tb/tb_dpf_fetch_ctrl.sv
module tb_dpf_fetch_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        br_valid, br_marked, br_lowconf, br_pred_taken;
    logic [31:0] br_taken_tgt, br_nt_tgt;
    logic [127:0] br_merge_addr;
    logic [3:0]  br_merge_vld;
    logic [7:0]  br_alt_limit;
    logic [31:0] next_fetch_addr;
    logic        fetch_valid, res_valid, res_mispred, ckpt_save, ckpt_restore;
    logic [1:0]  mode;
    logic [2:0]  evt;
    logic        redir_valid;
    logic [31:0] redir_addr;
    logic        flush_req;

    always #10 clk = ~clk;

    dpf_fetch_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .br_valid(br_valid), .br_marked(br_marked), .br_lowconf(br_lowconf),
        .br_pred_taken(br_pred_taken), .br_taken_tgt(br_taken_tgt), .br_nt_tgt(br_nt_tgt),
        .br_merge_addr(br_merge_addr), .br_merge_vld(br_merge_vld), .br_alt_limit(br_alt_limit),
        .next_fetch_addr(next_fetch_addr), .fetch_valid(fetch_valid),
        .res_valid(res_valid), .res_mispred(res_mispred),
        .ckpt_save(ckpt_save), .ckpt_restore(ckpt_restore),
        .mode(mode), .evt(evt), .redir_valid(redir_valid), .redir_addr(redir_addr),
        .flush_req(flush_req)
    );

    int total = 0;
    int bad   = 0;

    // Behavioural reference state
    int          m_st, m_sel, m_cnt, m_lim;
    logic [31:0] m_tab [4];
    logic        m_vld [4];
    logic [31:0] m_alt;
    int          s_st, s_sel, s_cnt, s_lim;
    logic [31:0] s_tab [4];
    logic        s_vld [4];
    logic [31:0] s_alt;
    int          e_evt;
    logic        e_rv, e_fl;
    logic [31:0] e_ra;

    task automatic model_reset();
        m_st = 0; m_sel = 0; m_cnt = 0; m_lim = 0; m_alt = '0;
        s_st = 0; s_sel = 0; s_cnt = 0; s_lim = 0; s_alt = '0;
        for (int i = 0; i < 4; i++) begin
            m_tab[i] = '0; m_vld[i] = 1'b0; s_tab[i] = '0; s_vld[i] = 1'b0;
        end
        e_evt = 0; e_rv = 0; e_fl = 0; e_ra = '0;
    endtask

    task automatic model_eval();
        bit   q;
        int   hi;
        int   nc;
        int   ev;
        q  = br_valid && br_marked && br_lowconf;
        hi = -1;
        for (int i = 0; i < 4; i++)
            if (hi < 0 && m_vld[i] && m_tab[i] == next_fetch_addr && (m_st != 2 || m_sel == i))
                hi = i;
        nc = (m_cnt == 255) ? 255 : m_cnt + 1;
        ev = 0;
        e_rv = 0; e_ra = '0;
        if (ckpt_restore) begin
            m_st = s_st; m_sel = s_sel; m_cnt = s_cnt; m_lim = s_lim; m_alt = s_alt;
            m_tab = s_tab; m_vld = s_vld;
        end else begin
            if (ckpt_save) begin
                s_st = m_st; s_sel = m_sel; s_cnt = m_cnt; s_lim = m_lim; s_alt = m_alt;
                s_tab = m_tab; s_vld = m_vld;
            end
            if (m_st == 0) begin
                if (q) ev = 1;
            end else if (m_st == 1) begin
                if (res_valid)   ev = res_mispred ? 7 : 6;
                else if (q)      ev = 1;
                else if (hi >= 0) ev = 2;
            end else begin
                if (res_valid)   ev = res_mispred ? 6 : 5;
                else if (hi >= 0) ev = 3;
                else if (fetch_valid && nc >= m_lim) ev = 4;
            end
            if (ev == 2) begin e_rv = 1; e_ra = m_alt; end
            if (ev == 4 || ev == 5) begin e_rv = 1; e_ra = m_tab[m_sel]; end
            case (ev)
                1: begin
                    m_st = 1; m_lim = br_alt_limit; m_sel = 0; m_cnt = 0;
                    m_alt = br_pred_taken ? br_nt_tgt : br_taken_tgt;
                    for (int i = 0; i < 4; i++) begin
                        m_tab[i] = br_merge_addr[i*32 +: 32];
                        m_vld[i] = br_merge_vld[i];
                    end
                end
                2: begin m_st = 2; m_sel = hi; m_cnt = 0; end
                3, 4, 5, 6, 7: m_st = 0;
                default: if (m_st == 2 && fetch_valid) m_cnt = nc;
            endcase
        end
        e_evt = ev;
        e_fl  = (ev == 7);
    endtask

    task automatic check(string tag);
        total++;
        if (evt !== e_evt[2:0] || redir_valid !== e_rv || redir_addr !== e_ra ||
            flush_req !== e_fl || mode !== m_st[1:0]) begin
            bad++;
            $display("FAIL %s: act evt=%0d rv=%0b ra=%h fl=%0b mode=%0d exp evt=%0d rv=%0b ra=%h fl=%0b mode=%0d",
                     tag, evt, redir_valid, redir_addr, flush_req, mode,
                     e_evt, e_rv, e_ra, e_fl, m_st);
        end
    endtask

    task automatic idle_inputs();
        br_valid = 0; br_marked = 0; br_lowconf = 0;
        fetch_valid = 0; res_valid = 0; res_mispred = 0;
        ckpt_save = 0; ckpt_restore = 0;
        next_fetch_addr = 32'h0000_F000;
    endtask

    task automatic cyc(string tag);
        model_eval();
        @(posedge clk);
        @(negedge clk);
        check(tag);
        idle_inputs();
    endtask

    task automatic set_branch(bit pt, logic [31:0] tt, logic [31:0] nt,
                              logic [31:0] a0, logic [31:0] a1, logic [31:0] a2,
                              logic [31:0] a3, logic [3:0] vm, logic [7:0] lim);
        br_valid = 1; br_marked = 1; br_lowconf = 1; br_pred_taken = pt;
        br_taken_tgt = tt; br_nt_tgt = nt;
        br_merge_addr = {a3, a2, a1, a0}; br_merge_vld = vm; br_alt_limit = lim;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle_inputs();
        br_pred_taken = 0; br_taken_tgt = '0; br_nt_tgt = '0;
        br_merge_addr = '0; br_merge_vld = '0; br_alt_limit = '0;
        model_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        check("R12 in reset");
        rst_n = 1;
        cyc("R12 after reset");

        // R1: flags missing
        set_branch(1, 32'h100, 32'h200, 32'h300, 32'h310, 32'h320, 32'h330, 4'b0111, 8'd10);
        br_marked = 0; cyc("R1 unmarked ignored");
        set_branch(1, 32'h100, 32'h200, 32'h300, 32'h310, 32'h320, 32'h330, 4'b0111, 8'd10);
        br_lowconf = 0; cyc("R1 confident ignored");
        // R1 enter, predicted taken
        set_branch(1, 32'h100, 32'h200, 32'h300, 32'h310, 32'h320, 32'h330, 4'b0111, 8'd10);
        cyc("R1 enter");
        next_fetch_addr = 32'h120; fetch_valid = 1; cyc("R2 follow predictor");
        next_fetch_addr = 32'h330; cyc("R3 invalid entry ignored");
        next_fetch_addr = 32'h310; cyc("R2 switch to alternate");
        next_fetch_addr = 32'h300; fetch_valid = 1; cyc("R3 other entry ignored in alt");
        set_branch(0, 32'h900, 32'h910, 32'h920, 32'h920, 32'h920, 32'h920, 4'b1111, 8'd1);
        cyc("R7 branch ignored in alt");
        fetch_valid = 1; cyc("R7 context kept");
        next_fetch_addr = 32'h310; cyc("R4 exit");

        // R3 duplicate match, R5 budget exit, predicted not taken
        set_branch(0, 32'h400, 32'h410, 32'h480, 32'h500, 32'h490, 32'h500, 4'b1111, 8'd3);
        cyc("R1 enter not-taken");
        next_fetch_addr = 32'h500; cyc("R3 lowest index taken, redirect to taken target");
        fetch_valid = 1; cyc("R5 count 1");
        fetch_valid = 1; cyc("R5 count 2");
        cyc("R5 no fetch no count");
        next_fetch_addr = 32'h490; cyc("R3 unlocked entry ignored");
        fetch_valid = 1; cyc("R5 early exit");

        // R5 precedence of merge match
        set_branch(1, 32'h600, 32'h610, 32'h620, 32'h0, 32'h0, 32'h0, 4'b0001, 8'd1);
        cyc("R1 enter");
        next_fetch_addr = 32'h620; cyc("R13 one event switch");
        next_fetch_addr = 32'h620; fetch_valid = 1; cyc("R5 match beats budget");

        // R6 re-entry, then R8 correct resolution in alt
        set_branch(1, 32'h100, 32'h200, 32'h300, 32'h0, 32'h0, 32'h0, 4'b0001, 8'd20);
        cyc("R1 enter");
        set_branch(0, 32'h111, 32'h222, 32'h0, 32'h0, 32'h700, 32'h0, 4'b0100, 8'd20);
        cyc("R6 re-enter");
        next_fetch_addr = 32'h300; cyc("R6 old table gone");
        next_fetch_addr = 32'h700; cyc("R6 new target used");
        res_valid = 1; res_mispred = 0; cyc("R8 correct in alt redirect");

        // R8 mispredicted in alt
        set_branch(1, 32'h100, 32'h200, 32'h300, 32'h0, 32'h0, 32'h0, 4'b0001, 8'd20);
        cyc("R1 enter");
        next_fetch_addr = 32'h300; cyc("R2 switch");
        res_valid = 1; res_mispred = 1; cyc("R8 mispredicted in alt release");

        // R9
        set_branch(1, 32'h100, 32'h200, 32'h300, 32'h0, 32'h0, 32'h0, 4'b0001, 8'd20);
        cyc("R1 enter");
        res_valid = 1; res_mispred = 0; cyc("R9 correct in pred release");
        set_branch(1, 32'h100, 32'h200, 32'h300, 32'h0, 32'h0, 32'h0, 4'b0001, 8'd20);
        cyc("R1 enter");
        res_valid = 1; res_mispred = 1; cyc("R9 mispredicted in pred flush");

        // R10
        res_valid = 1; res_mispred = 1; cyc("R10 resolution in normal ignored");
        set_branch(1, 32'h100, 32'h200, 32'h300, 32'h0, 32'h0, 32'h0, 4'b0001, 8'd20);
        cyc("R1 enter");
        next_fetch_addr = 32'h300; res_valid = 1; cyc("R10 resolution beats hit");

        // R11 checkpoint
        set_branch(1, 32'h100, 32'h200, 32'h300, 32'h310, 32'h0, 32'h0, 4'b0011, 8'd20);
        cyc("R1 enter");
        ckpt_save = 1; cyc("R11 save in pred");
        next_fetch_addr = 32'h310; cyc("R2 switch");
        ckpt_restore = 1; cyc("R11 restore to pred");
        next_fetch_addr = 32'h300; cyc("R11 restored table");
        ckpt_restore = 1; res_valid = 1; next_fetch_addr = 32'h300; cyc("R11 restore beats all");
        res_valid = 1; res_mispred = 1; cyc("R9 flush after restore");
        cyc("R12 idle");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule